// File: doc/BRIEF.md
# Dual-Loop Tri-State Phase Comparator with Lock Detection

This block compares, for each of several synthesizer loops, a reference strobe with a divided feedback strobe, one clock wide each, and turns the timing difference into two charge-pump command enables. The source enable means "push current in". The sink enable means "pull current out". When neither is raised, the pump output floats. A per-loop polarity input swaps the two enables, so either VCO slope can be served. Every comparison ends with one cycle in which both enables are raised together. This balanced pulse keeps the detector free of a dead zone, and the pump output still stays net-neutral at zero phase error. The whole block runs on the reference oscillator clock, so a phase error is a whole number of oscillator periods.

Each loop has a lock tracker that judges every finished comparison. A large error clears lock at once. A run of small-error comparisons sets lock. A per-loop power-save input idles that loop's comparator, forces its pump output to float and makes that loop count as locked. On the first comparison after power save is released, the lone enable pulse is clamped, so the VCO does not jump. A single monitor pin carries either the combined lock flag of all loops or one of the raw strobes.

Top module: `dual_pfd_lock`

## Requirements
- R1: While reset is asserted, every source and sink enable is low and, with no loop in power save, `lock_all` is low.
- R2: With polarity 1, a reference strobe that leads the feedback strobe by k clock cycles (k ≥ 1) raises the source enable alone for exactly k cycles, starting in the cycle after the reference strobe is sampled. Both enables are then high for exactly one cycle, and then both are low.
- R3: With polarity 1, a feedback strobe that leads by k cycles raises the sink enable alone for k cycles, followed by the one-cycle balanced pulse.
- R4: With polarity 0, the roles of the source and sink enables in R2 and R3 are exchanged.
- R5: Reference and feedback strobes sampled in the same cycle produce no lone pulse and exactly one cycle with both enables high (phase error 0).
- R6: A further strobe of the leading input, arriving while the comparator waits for the lagging one, is ignored. The lone pulse still measures from the first leading strobe.
- R7: A loop becomes locked after 3 consecutive comparisons whose error is at most 2 cycles. The flag changes in the cycle after the balanced pulse.
- R8: A comparison with an error of 4 cycles or more clears that loop's lock at once. An error of exactly 3 leaves the lock flag unchanged but restarts the small-error run.
- R9: While a loop's power-save input is high, its enables are low from the next cycle on and the loop counts as locked. Its internal lock state is cleared, so after release it reads unlocked until R7 is met again. Power save takes priority over a lock decision that falls in the same cycle.
- R10: On the first comparison after power save is released, the lone enable lasts at most 2 cycles. The balanced pulse is still issued, and the error that the lock tracker judges is the true, unclamped one. Later comparisons are not clamped.
- R11: `lock_all` is high only when every loop is locked or in power save.
- R12: With `mon_en` low, `mon_out` equals `lock_all`. With `mon_en` high, `mon_out` passes through, in the same cycle, the strobe picked by `mon_sel`: 0 = reference of loop 0, 1 = reference of loop 1, 2 = feedback of loop 0, 3 = feedback of loop 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | NLOOP | Reference comparison strobe, one bit per loop |
| fb_stb | input | NLOOP | Divided feedback strobe, one bit per loop |
| pol | input | NLOOP | Output polarity per loop (1 = source when reference leads) |
| sleep | input | NLOOP | Power-save request per loop |
| mon_en | input | 1 | Monitor pin carries a strobe (1) or the combined lock (0) |
| mon_sel | input | SW | Strobe select for the monitor pin |
| src_en | output | NLOOP | Charge-pump source command |
| snk_en | output | NLOOP | Charge-pump sink command |
| lock_all | output | 1 | Combined lock of all loops |
| mon_out | output | 1 | Monitor pin |

## Verification
Two events can coincide: a loop's power-save request and the lock decision that a just-finished comparison would apply. The bench provokes this by raising power save in the cycle that the balanced pulse is visible, so the tracker sees both the completion and the sleep request on the same edge. It then checks three things: the loop reads as locked while asleep, its enables stay low, and after release it reads unlocked. This shows that power save won and the pending decision was dropped.

// File: rtl/dual_pfd_lock_pkg.sv
package dual_pfd_lock_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REF  = 2'd1,
        PH_FB   = 2'd2
    } phase_e;

endpackage

// File: rtl/pfd_lane.sv
module pfd_lane
    import dual_pfd_lock_pkg::*;
#(
    parameter int CW    = 8,
    parameter int CLAMP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_stb,
    input  logic          fb_stb,
    input  logic          pol,
    input  logic          sleep,
    output logic          src_en,
    output logic          snk_en,
    output logic          done,
    output logic [CW-1:0] err
);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          up;
        logic          dn;
        logic          first;
        logic          done;
        logic [CW-1:0] err;
    } lane_t;

    localparam logic [CW-1:0] CNT_ONE   = CW'(1);
    localparam logic [CW-1:0] CLAMP_LIM = CW'(CLAMP);

    lane_t q, d;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
        return (c == '1) ? c : c + CNT_ONE;
    endfunction

    // lone pulse allowed unless this is the clamped first comparison
    function automatic logic lone_ok(input logic first, input logic [CW-1:0] c);
        return !(first && (c > CLAMP_LIM));
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.up   = 1'b0;
        d.dn   = 1'b0;
        if (sleep) begin
            d.ph    = PH_IDLE;
            d.cnt   = '0;
            d.err   = '0;
            d.first = 1'b1;
        end else begin
            case (q.ph)
                PH_IDLE: begin
                    if (ref_stb && fb_stb) begin
                        d.done  = 1'b1;
                        d.err   = '0;
                        d.up    = 1'b1;
                        d.dn    = 1'b1;
                        d.first = 1'b0;
                    end else if (ref_stb) begin
                        d.ph  = PH_REF;
                        d.cnt = CNT_ONE;
                        d.up  = lone_ok(q.first, CNT_ONE);
                    end else if (fb_stb) begin
                        d.ph  = PH_FB;
                        d.cnt = CNT_ONE;
                        d.dn  = lone_ok(q.first, CNT_ONE);
                    end
                end
                PH_REF: begin
                    if (fb_stb) begin
                        d.ph    = PH_IDLE;
                        d.done  = 1'b1;
                        d.err   = q.cnt;
                        d.up    = 1'b1;
                        d.dn    = 1'b1;
                        d.first = 1'b0;
                    end else begin
                        d.cnt = sat_inc(q.cnt);
                        d.up  = lone_ok(q.first, d.cnt);
                    end
                end
                PH_FB: begin
                    if (ref_stb) begin
                        d.ph    = PH_IDLE;
                        d.done  = 1'b1;
                        d.err   = q.cnt;
                        d.up    = 1'b1;
                        d.dn    = 1'b1;
                        d.first = 1'b0;
                    end else begin
                        d.cnt = sat_inc(q.cnt);
                        d.dn  = lone_ok(q.first, d.cnt);
                    end
                end
                default: begin
                    d.ph  = PH_IDLE;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph    <= PH_IDLE;
            q.cnt   <= '0;
            q.up    <= 1'b0;
            q.dn    <= 1'b0;
            q.first <= 1'b0;
            q.done  <= 1'b0;
            q.err   <= '0;
        end else begin
            q <= d;
        end
    end

    assign src_en = pol ? q.up : q.dn;
    assign snk_en = pol ? q.dn : q.up;
    assign done   = q.done;
    assign err    = q.err;

endmodule

// File: rtl/lock_track.sv
module lock_track #(
    parameter int CW      = 8,
    parameter int GOOD_TH = 2,
    parameter int LOSE_TH = 4,
    parameter int RUN_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          done,
    input  logic [CW-1:0] err,
    output logic          locked
);

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_ONE  = RW'(1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(RUN_LEN);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          lock;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (sleep) begin
            d.run  = '0;
            d.lock = 1'b0;
        end else if (done) begin
            if (err >= CW'(LOSE_TH)) begin
                d.run  = '0;
                d.lock = 1'b0;
            end else if (err <= CW'(GOOD_TH)) begin
                if (q.run >= RUN_LAST) begin
                    d.run  = RUN_FULL;
                    d.lock = 1'b1;
                end else begin
                    d.run = q.run + RUN_ONE;
                end
            end else begin
                d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.run  <= '0;
            q.lock <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign locked = q.lock;

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
    parameter int NLOOP   = 2,
    parameter int CW      = 8,
    parameter int CLAMP   = 2,
    parameter int GOOD_TH = 2,
    parameter int LOSE_TH = 4,
    parameter int RUN_LEN = 3,
    parameter int SW      = $clog2(2 * NLOOP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLOOP-1:0] ref_stb,
    input  logic [NLOOP-1:0] fb_stb,
    input  logic [NLOOP-1:0] pol,
    input  logic [NLOOP-1:0] sleep,
    input  logic             mon_en,
    input  logic [SW-1:0]    mon_sel,
    output logic [NLOOP-1:0] src_en,
    output logic [NLOOP-1:0] snk_en,
    output logic             lock_all,
    output logic             mon_out
);

    localparam int NTAP = 2 * NLOOP;
    localparam int TAPW = 1 << SW;

    logic [NLOOP-1:0]         done_w;
    logic [NLOOP-1:0][CW-1:0] err_w;
    logic [NLOOP-1:0]         lock_w;
    logic [NLOOP-1:0]         loop_ok;
    logic [TAPW-1:0]          taps;

    for (genvar g = 0; g < NLOOP; g++) begin : g_loop
        pfd_lane #(
            .CW    (CW),
            .CLAMP (CLAMP)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_stb (ref_stb[g]),
            .fb_stb  (fb_stb[g]),
            .pol     (pol[g]),
            .sleep   (sleep[g]),
            .src_en  (src_en[g]),
            .snk_en  (snk_en[g]),
            .done    (done_w[g]),
            .err     (err_w[g])
        );

        lock_track #(
            .CW      (CW),
            .GOOD_TH (GOOD_TH),
            .LOSE_TH (LOSE_TH),
            .RUN_LEN (RUN_LEN)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .sleep  (sleep[g]),
            .done   (done_w[g]),
            .err    (err_w[g]),
            .locked (lock_w[g])
        );

        assign loop_ok[g] = lock_w[g] | sleep[g];
    end

    assign lock_all = &loop_ok;

    always_comb begin
        taps              = '0;
        taps[NTAP-1:0]    = {fb_stb, ref_stb};
        mon_out           = mon_en ? taps[mon_sel] : lock_all;
    end

endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk #(
    parameter int NLOOP   = 2,
    parameter int CW      = 8,
    parameter int GOOD_TH = 2,
    parameter int LOSE_TH = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NLOOP-1:0]         sleep,
    input logic [NLOOP-1:0]         src,
    input logic [NLOOP-1:0]         snk,
    input logic [NLOOP-1:0]         done_w,
    input logic [NLOOP-1:0][CW-1:0] err_w,
    input logic [NLOOP-1:0]         lock_w
);

    for (genvar g = 0; g < NLOOP; g++) begin : g_chk
        // R9: a sleeping loop drives no pump command on the following cycle
        p_sleep_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sleep[g] |=> (!src[g] && !snk[g]));

        // R7: lock only rises right after a finished comparison
        p_lock_rise_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock_w[g]) |-> $past(done_w[g]));

        // R7: and that comparison had a small error
        p_lock_rise_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock_w[g]) |-> ($past(err_w[g]) <= CW'(GOOD_TH)));

        // R8: lock only falls on a large error or on power save
        p_lock_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lock_w[g]) |-> ($past(sleep[g]) ||
                                  ($past(done_w[g]) && ($past(err_w[g]) >= CW'(LOSE_TH)))));
    end

endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(
    .NLOOP   (NLOOP),
    .CW      (CW),
    .GOOD_TH (GOOD_TH),
    .LOSE_TH (LOSE_TH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sleep  (sleep),
    .src    (src_en),
    .snk    (snk_en),
    .done_w (done_w),
    .err_w  (err_w),
    .lock_w (lock_w)
);

// File: tb/dual_pfd_lock_tb.sv
`timescale 1ns/1ps
module dual_pfd_lock_tb;

    localparam int NLOOP = 2;
    localparam int CLAMP = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NLOOP-1:0] ref_stb = '0;
    logic [NLOOP-1:0] fb_stb = '0;
    logic [NLOOP-1:0] pol = '1;
    logic [NLOOP-1:0] sleep = '0;
    logic             mon_en = 1'b0;
    logic [1:0]       mon_sel = '0;
    logic [NLOOP-1:0] src_en;
    logic [NLOOP-1:0] snk_en;
    logic             lock_all;
    logic             mon_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int e_run   [NLOOP];
    bit e_lock  [NLOOP];
    bit e_first [NLOOP];

    always #4 clk = ~clk;

    dual_pfd_lock u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_stb  (ref_stb),
        .fb_stb   (fb_stb),
        .pol      (pol),
        .sleep    (sleep),
        .mon_en   (mon_en),
        .mon_sel  (mon_sel),
        .src_en   (src_en),
        .snk_en   (snk_en),
        .lock_all (lock_all),
        .mon_out  (mon_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected lock evolution after one finished comparison
    function automatic void mdl_judge(input int ln, input int err);
        if (err >= 4) begin
            e_lock[ln] = 0;
            e_run[ln]  = 0;
        end else if (err <= 2) begin
            e_run[ln]++;
            if (e_run[ln] >= 3) e_lock[ln] = 1;
        end else begin
            e_run[ln] = 0;
        end
    endfunction

    function automatic bit exp_all();
        bit r = 1;
        for (int i = 0; i < NLOOP; i++) r &= (sleep[i] | e_lock[i]);
        return r;
    endfunction

    // called right after a negedge
    task automatic set_sleep(input int ln, input bit v);
        sleep[ln] = v;
        if (v) begin
            e_lock[ln]  = 0;
            e_run[ln]   = 0;
            e_first[ln] = 1;
        end
    endtask

    task automatic set_lead(input int ln, input bit rlead);
        if (rlead) ref_stb[ln] = 1'b1;
        else       fb_stb[ln]  = 1'b1;
    endtask

    // one comparison: leader strobe, trailer k cycles later
    task automatic do_cmp(input int ln, input bit rlead, input int k,
                          input bit dup, input bit sleep_end, input string tag);
        int lone_ok_n = 0;
        int lone_bad_n = 0;
        int both_n = 0;
        int exp_lone;
        bit on_src;
        on_src   = (rlead == pol[ln]);
        exp_lone = (e_first[ln] && k > CLAMP) ? CLAMP : k;
        @(negedge clk);
        set_lead(ln, rlead);
        if (k == 0) set_lead(ln, !rlead);
        for (int j = 1; j <= k + 2; j++) begin
            @(negedge clk);
            if (src_en[ln] && snk_en[ln]) both_n++;
            else if (src_en[ln]) begin if (on_src) lone_ok_n++; else lone_bad_n++; end
            else if (snk_en[ln]) begin if (!on_src) lone_ok_n++; else lone_bad_n++; end
            ref_stb[ln] = 1'b0;
            fb_stb[ln]  = 1'b0;
            if (k > 0 && j == k) set_lead(ln, !rlead);
            if (dup && j == 1 && k >= 3) set_lead(ln, rlead);
            if (sleep_end && j == k + 1) sleep[ln] = 1'b1;
        end
        chk(lone_ok_n == exp_lone, tag, lone_ok_n, exp_lone);
        chk(lone_bad_n == 0, tag, lone_bad_n, 0);
        chk(both_n == 1, {tag, " balanced pulse R5"}, both_n, 1);
        if (sleep_end) begin
            e_lock[ln]  = 0;
            e_run[ln]   = 0;
            e_first[ln] = 1;
        end else begin
            mdl_judge(ln, k);
            e_first[ln] = 0;
        end
        chk(lock_all == exp_all(), "R7 lock after comparison", lock_all, exp_all());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NLOOP; i++) begin
            e_run[i] = 0; e_lock[i] = 0; e_first[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(src_en == '0, "R1 src", src_en, 0);
        chk(snk_en == '0, "R1 snk", snk_en, 0);
        chk(lock_all == 1'b0, "R1 lock_all", lock_all, 0);
        rst_n = 1'b1;
        @(negedge clk);
        set_sleep(1, 1);

        pol[0] = 1'b1;
        do_cmp(0, 1, 3, 0, 0, "R2 ref leads");
        do_cmp(0, 0, 2, 0, 0, "R3 fb leads");
        pol[0] = 1'b0;
        do_cmp(0, 1, 4, 0, 0, "R4 swapped polarity");
        do_cmp(0, 0, 1, 0, 0, "R4 swapped polarity");
        pol[0] = 1'b1;
        do_cmp(0, 1, 0, 0, 0, "R5 zero error");
        do_cmp(0, 1, 4, 1, 0, "R6 repeated leader");

        // R7 lock acquisition
        do_cmp(0, 1, 1, 0, 0, "R7 good");
        do_cmp(0, 0, 2, 0, 0, "R7 good");
        chk(lock_all == 1'b0, "R7 not yet locked", lock_all, 0);
        do_cmp(0, 1, 1, 0, 0, "R7 good");
        chk(lock_all == 1'b1, "R7 locked after three", lock_all, 1);

        // R8 hysteresis and loss
        do_cmp(0, 1, 3, 0, 0, "R8 middle error");
        chk(lock_all == 1'b1, "R8 middle keeps lock", lock_all, 1);
        do_cmp(0, 0, 5, 0, 0, "R8 large error");
        chk(lock_all == 1'b0, "R8 large drops lock", lock_all, 0);
        repeat (3) do_cmp(0, 1, 2, 0, 0, "R7 relock");
        chk(lock_all == 1'b1, "R7 relocked", lock_all, 1);

        // R9 power save colliding with a lock decision
        do_cmp(0, 1, 1, 0, 1, "R9 sleep at decision");
        chk(lock_all == 1'b1, "R9 asleep counts locked", lock_all, 1);
        @(negedge clk);
        chk(src_en[0] == 1'b0 && snk_en[0] == 1'b0, "R9 float while asleep",
            {src_en[0], snk_en[0]}, 0);
        set_sleep(0, 0);
        @(negedge clk);
        chk(lock_all == 1'b0, "R9 unlocked after wake", lock_all, 0);

        // R10 clamp on first comparison after wake, then normal
        do_cmp(0, 1, 5, 0, 0, "R10 clamped first");
        do_cmp(0, 1, 5, 0, 0, "R10 unclamped second");
        @(negedge clk);
        set_sleep(0, 1);
        @(negedge clk);
        set_sleep(0, 0);
        do_cmp(0, 0, 4, 0, 0, "R10 clamped fb lead");

        // R11 combined lock across loops
        repeat (3) do_cmp(0, 1, 1, 0, 0, "R11 lock loop0");
        @(negedge clk);
        set_sleep(1, 0);
        @(negedge clk);
        chk(lock_all == 1'b0, "R11 loop1 awake unlocked", lock_all, 0);
        set_sleep(0, 1);
        repeat (3) do_cmp(1, 0, 2, 0, 0, "R11 lock loop1");
        chk(lock_all == 1'b1, "R11 loop1 locked, loop0 asleep", lock_all, 1);
        @(negedge clk);
        set_sleep(0, 0);
        @(negedge clk);
        chk(lock_all == 1'b0, "R11 loop0 woke unlocked", lock_all, 0);
        set_sleep(0, 1);
        set_sleep(1, 1);
        @(negedge clk);
        chk(lock_all == 1'b1, "R11 both asleep", lock_all, 1);

        // R12 monitor selection, both loops asleep
        mon_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            mon_sel = 2'(s);
            ref_stb = '0; fb_stb = '0;
            if (s < 2) ref_stb[s] = 1'b1; else fb_stb[s-2] = 1'b1;
            #1 chk(mon_out == 1'b1, "R12 tap selected high", mon_out, 1);
            ref_stb = ~ref_stb; fb_stb = ~fb_stb;
            #1 chk(mon_out == 1'b0, "R12 tap selected low", mon_out, 0);
        end
        @(negedge clk);
        ref_stb = '0; fb_stb = '0;
        mon_en = 1'b0;
        #1 chk(mon_out == lock_all && mon_out == exp_all(), "R12 lock on pin", mon_out, exp_all());

        // random comparisons
        for (int it = 0; it < 60; it++) begin
            int ln;
            int gap;
            ln = int'($urandom_range(0, 1));
            @(negedge clk);
            set_sleep(1 - ln, 1);
            set_sleep(ln, 0);
            pol[ln] = 1'($urandom_range(0, 1));
            gap = int'($urandom_range(0, 3));
            repeat (gap) @(negedge clk);
            do_cmp(ln, 1'($urandom_range(0, 1)), int'($urandom_range(0, 6)), 0, 0,
                   "R2 random comparison");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule